// File: doc/BRIEF.md
# Preloadable Watchdog Timer with Stretched Reset Pulse

This block is a watchdog built on an 8-bit up-counter. The counter advances on ticks from one of two prescaled sources. The first is the base clock divided by a fixed ratio. The second is a subclock enable input divided by a smaller ratio. When a tick arrives while the count is at its maximum, the counter overflows. The block then raises an internal reset output one base clock later and holds it high for a fixed number of base clock cycles.

Software reaches the block over a small synchronous register bus. Reads are combinational. There are three registers:

- a control/status register, in which the run bit is guarded by a write-enable bit;
- the counter itself, which software may preload at any time to set a timeout of 1 to 256 ticks;
- a source-select bit.

Starting the watchdog takes two control writes. The first sets the write-enable bit. The second sets the run bit and clears the protect bit in the same access.

Once the reset pulse ends, the block returns to its post-reset state. The whole block runs in one clock domain, and the subclock appears only as a single-cycle enable.

Top module: `guard_timer`

## Requirements
- R1: While the run bit is set and no reset pulse is pending or active, each tick of the selected source raises the counter by exactly one, modulo 256.
- R2: The source register (bus_sel = 2) holds the select in bit 0. Select 0 produces a tick once every SYS_DIV base cycles (default 8192). Select 1 produces a tick once every SUB_DIV pulses of sub_en (default 32).
- R3: The control register (bus_sel = 0) has bit 0 = write-enable, bit 1 = protect and bit 2 = run, and reads back as run, constant 1, write-enable in those bits. Every control write loads write-enable from bit 0. The run bit loads from bit 2 only if write-enable was already set and bit 1 of the write is 0; otherwise run is unchanged.
- R4: A tick that arrives while the count is 0xFF wraps the counter to 0 and counts as an overflow.
- R5: A write to the counter (bus_sel = 1) loads the written value and takes priority over a tick in the same cycle. After a preload of P, overflow comes on tick 256 − P.
- R6: wd_rst goes high exactly one base cycle after the clock edge on which the overflow happens.
- R7: wd_rst stays high for exactly PULSE_LEN base cycles (default 512).
- R8: From the overflow until wd_rst falls, ticks have no effect, no further overflow occurs, and bus writes are ignored.
- R9: After rst_n and after wd_rst falls, the block is in its reset state: counter 0, run 0, write-enable 0, select 0, and both prescalers restarted. The control register then reads 0x02.
- R10: While the run bit is clear, the counter holds its value except when it is written.
- R11: With write-enable set, a control write with bits 2 and 1 both clear stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_en | input | 1 | Single-cycle subclock enable |
| bus_sel | input | 2 | Register select: 0 control, 1 counter, 2 source |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data of the selected register |
| wd_rst | output | 1 | Watchdog reset pulse |

## Verification
The main function is run with every preload value from 0 to 255 on the subclock source, which shows that the number of ticks to overflow is 256 − P across the whole range, including the one-tick and full-range ends. The tick spacing is measured on the base-clock source and on a subclock whose enable fires every third cycle, which separates the two dividers and the select. The enable protocol is tried with four write patterns: run without write-enable, run with protect set, a proper two-write start, and a two-write stop. Pulses that end with and without bus writes during the pulse show that those writes are ignored and that the state clears afterwards.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_SRC   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int CTL_WREN = 0;
    localparam int CTL_LOCK = 1;
    localparam int CTL_RUN  = 2;

endpackage

// File: rtl/guard_timer_presc.sv
module guard_timer_presc #(
    parameter int DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic tick
);
    localparam int          W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    always_comb begin
        tick = adv && (st_q.cnt == LAST);
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/guard_timer_stretch.sv
module guard_timer_stretch #(
    parameter int LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int           W   = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [W-1:0] FIN = W'(LEN - 1);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic         act;
        logic [W-1:0] cnt;
    } stretch_st_t;

    stretch_st_t st_d, st_q;

    always_comb begin
        last   = st_q.act && (st_q.cnt == FIN);
        active = st_q.act;
        st_d   = st_q;
        if (st_q.act) begin
            if (last) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (start) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SYS_DIV   = 8192,
    parameter int SUB_DIV   = 32,
    parameter int PULSE_LEN = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_en,
    input  logic [1:0]       bus_sel,
    input  logic             bus_we,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             wd_rst
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             wren;
        logic             src;
        logic             ovf;
    } wdt_st_t;

    wdt_st_t st_d, st_q;

    logic sys_tick, sub_tick, tick;
    logic pulse_act, pulse_last, soft_clr;
    logic busy, wr_ok, wr_ctrl, wr_cnt, wr_src, adv;

    assign soft_clr = pulse_last;

    guard_timer_presc #(.DIV(SYS_DIV)) sys_presc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .adv  (1'b1),
        .tick (sys_tick)
    );

    guard_timer_presc #(.DIV(SUB_DIV)) sub_presc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .adv  (sub_en),
        .tick (sub_tick)
    );

    guard_timer_stretch #(.LEN(PULSE_LEN)) stretch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (st_q.ovf),
        .active(pulse_act),
        .last  (pulse_last)
    );

    always_comb begin
        busy    = st_q.ovf | pulse_act;
        wr_ok   = bus_we & ~busy;
        wr_ctrl = wr_ok && (bus_sel == REG_CTRL);
        wr_cnt  = wr_ok && (bus_sel == REG_COUNT);
        wr_src  = wr_ok && (bus_sel == REG_SRC);
        tick    = st_q.src ? sub_tick : sys_tick;
        adv     = st_q.run & tick & ~busy;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (soft_clr) begin
            st_d = '0;
        end else begin
            if (wr_ctrl) begin
                st_d.wren = bus_wdata[CTL_WREN];
                if (st_q.wren && !bus_wdata[CTL_LOCK]) begin
                    st_d.run = bus_wdata[CTL_RUN];
                end
            end
            if (wr_src) begin
                st_d.src = bus_wdata[0];
            end
            if (wr_cnt) begin
                st_d.cnt = bus_wdata;
            end else if (adv) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
                if (st_q.cnt == CNT_MAX) begin
                    st_d.ovf = 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            REG_CTRL: begin
                bus_rdata[CTL_RUN]  = st_q.run;
                bus_rdata[CTL_LOCK] = 1'b1;
                bus_rdata[CTL_WREN] = st_q.wren;
            end
            REG_COUNT: bus_rdata    = st_q.cnt;
            REG_SRC:   bus_rdata[0] = st_q.src;
            default:   bus_rdata    = '0;
        endcase
    end

    assign wd_rst = pulse_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             wren,
    input logic             adv,
    input logic             wr_cnt,
    input logic             ovf,
    input logic             soft_clr,
    input logic [CNT_W-1:0] cnt,
    input logic             wd_rst
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
        end else if (wd_rst) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= 0;
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !wr_cnt && !soft_clr |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !wr_cnt && (cnt == '1) |=> ovf && (cnt == '0)); // R4
    AST_ENABLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(wren)); // R3
    AST_PULSE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> $rose(wd_rst)); // R6
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> hi_cnt == PULSE_LEN); // R7
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= PULSE_LEN); // R7
    AST_QUIET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> !adv && !ovf); // R8
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_cnt && !soft_clr |=> $stable(cnt)); // R10
    AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_rst) |-> (cnt == '0) && !run && !wren); // R9

endmodule

bind guard_timer guard_timer_chk #(
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q.run),
    .wren    (st_q.wren),
    .adv     (adv),
    .wr_cnt  (wr_cnt),
    .ovf     (st_q.ovf),
    .soft_clr(soft_clr),
    .cnt     (st_q.cnt),
    .wd_rst  (wd_rst)
);

// File: tb/guard_timer_tb_top.sv
`timescale 1ns/1ps
module guard_timer_tb_top;
    import guard_timer_pkg::*;

    localparam int CNT_W     = 8;
    localparam int SYS_DIV   = 4;
    localparam int SUB_DIV   = 2;
    localparam int PULSE_LEN = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sub_en = 1'b0;
    logic [1:0]       bus_sel;
    logic             bus_we;
    logic [CNT_W-1:0] bus_wdata;
    logic [CNT_W-1:0] bus_rdata;
    logic             wd_rst;

    int checks = 0;
    int fails = 0;
    int sub_period = 0;
    int ph = 0;

    always #4 clk = ~clk;

    guard_timer #(
        .CNT_W(CNT_W), .SYS_DIV(SYS_DIV), .SUB_DIV(SUB_DIV), .PULSE_LEN(PULSE_LEN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sub_en(sub_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst(wd_rst)
    );

    initial forever begin
        @(negedge clk);
        ph = ph + 1;
        sub_en = (sub_period != 0) && (ph % sub_period == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_sel = a; bus_we = 1'b1; bus_wdata = CNT_W'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_sel = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic arm(input int src);
        wr(REG_SRC, src);
        wr(REG_CTRL, 1);
        wr(REG_CTRL, 4);
    endtask

    // measure spacing of counter steps while running
    task automatic intervals(input int n, input int exp_gap, input string tag);
        int prev, v, last_cyc, cyc, seen;
        rd(REG_COUNT, prev);
        cyc = 0; last_cyc = -1; seen = 0;
        while (seen < n && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            v = int'(bus_rdata);
            if (v != prev) begin
                check({tag, " R1 step by one"}, v, (prev + 1) & 255);
                if (last_cyc >= 0) check({tag, " R2 tick spacing"}, cyc - last_cyc, exp_gap);
                last_cyc = cyc; prev = v; seen++;
            end
        end
        check({tag, " R2 steps seen"}, seen, n);
    endtask

    task automatic run_overflow(input int p, input int src, input bit poke);
        int prev, v, changes, wrap_cyc, cyc, rise, stepbad, hi, held;
        wr(REG_COUNT, p);
        arm(src);
        rd(REG_COUNT, prev);
        changes = 0; wrap_cyc = -1; cyc = 0; rise = -1; stepbad = 0;
        while (cyc < 6000) begin
            @(negedge clk);
            cyc++;
            v = int'(bus_rdata);
            if (wd_rst) begin rise = cyc; break; end
            if (v != prev) begin
                changes++;
                if (v != ((prev + 1) & 255)) stepbad++;
                if (v == 0) wrap_cyc = cyc;
                prev = v;
            end
        end
        check($sformatf("R5 ticks to overflow p=%0d", p), changes, 256 - p);
        check($sformatf("R1 unit steps p=%0d", p), stepbad, 0);
        check($sformatf("R4 wrap seen p=%0d", p), int'(wrap_cyc > 0), 1);
        check($sformatf("R6 pulse one cycle after wrap p=%0d", p), rise, wrap_cyc + 1);
        if (!poke) begin
            hi = 1; held = 0;
            while (hi < 4 * PULSE_LEN) begin
                @(negedge clk);
                if (!wd_rst) break;
                hi++;
                if (bus_rdata != 0) held++;
            end
            check($sformatf("R7 pulse width p=%0d", p), hi, PULSE_LEN);
            check($sformatf("R8 counter frozen in pulse p=%0d", p), held, 0);
        end else begin
            wr(REG_COUNT, 8'h55);
            wr(REG_SRC, 1);
            wr(REG_CTRL, 1);
            bus_sel = REG_COUNT;
            hi = 0;
            while (wd_rst && hi < 4 * PULSE_LEN) begin @(negedge clk); hi++; end
        end
        rd(REG_CTRL, v);  check($sformatf("R9 ctrl after pulse p=%0d", p), v, 2);
        rd(REG_COUNT, v); check($sformatf("R9 R8 count after pulse p=%0d", p), v, 0);
        rd(REG_SRC, v);   check($sformatf("R9 R8 select after pulse p=%0d", p), v, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v, v2;
        rst_n = 1'b0; bus_sel = REG_CTRL; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        rd(REG_CTRL, v);  check("R9 reset ctrl", v, 2);
        rd(REG_COUNT, v); check("R9 reset count", v, 0);
        rd(REG_SRC, v);   check("R9 reset select", v, 0);
        check("R9 reset pulse low", int'(wd_rst), 0);

        // R10 hold while stopped
        wr(REG_COUNT, 8'h10);
        repeat (40) @(negedge clk);
        rd(REG_COUNT, v); check("R10 hold while stopped", v, 16);

        // R3 run without write-enable ignored
        wr(REG_CTRL, 4);
        rd(REG_CTRL, v); check("R3 run ignored without wren", v, 2);
        repeat (20) @(negedge clk);
        rd(REG_COUNT, v); check("R3 counter still held", v, 16);
        // R3 protect bit set blocks run
        wr(REG_CTRL, 1);
        rd(REG_CTRL, v); check("R3 wren set", v, 3);
        wr(REG_CTRL, 6);
        rd(REG_CTRL, v); check("R3 protect blocks run, wren cleared", v, 2);
        // R3 proper start
        wr(REG_CTRL, 1);
        wr(REG_CTRL, 4);
        rd(REG_CTRL, v); check("R3 two-write start", v, 6);
        intervals(6, SYS_DIV, "base source");

        // R11 stop
        wr(REG_CTRL, 1);
        wr(REG_CTRL, 0);
        rd(REG_CTRL, v); check("R11 stopped", v, 2);
        rd(REG_COUNT, v);
        repeat (30) @(negedge clk);
        rd(REG_COUNT, v2); check("R11 count held after stop", v2, v);

        // R2 subclock every third cycle
        sub_period = 3;
        wr(REG_COUNT, 0);
        arm(1);
        intervals(6, 3 * SUB_DIV, "sub source");
        wr(REG_CTRL, 1);
        wr(REG_CTRL, 0);

        // fresh reset, then full preload sweep on subclock
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        rd(REG_CTRL, v); check("R9 ctrl after second reset", v, 2);
        sub_period = 1;
        for (int p = 0; p < 256; p++) run_overflow(p, 1, 1'b0);

        // base-clock source overflow, and writes during the pulse
        sub_period = 0;
        run_overflow(8'hFA, 0, 1'b0);
        run_overflow(8'hFE, 0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule